// File: doc/BRIEF.md
# Iterative Accumulator Normalize Unit

This unit left-justifies a 32-bit accumulator value. It shifts the operand left by one bit per clock until the most significant bit is set. It then writes the shifted value to the accumulator result register and the number of shifts to an 8-bit shift-count register. It also sets a zero flag when the operand held no set bit. The latency depends on the data and matches a fixed cycle budget: an all-zero operand takes 4 cycles, and any other operand takes 6 cycles plus the number of shifts.

A one-cycle `start` pulse seen while the unit is idle captures `acc_in` and begins the operation. `busy` is high for exactly the cycle budget of the operation. `done` is a one-cycle pulse in the last busy cycle. The result registers change at the clock edge that ends the `done` cycle. From the first cycle with `busy` low, the results can be read, and they hold until the next operation ends.

The controller has six states. `ST_IDLE` waits for a start. `ST_FETCH` is the operand fetch cycle. `ST_TEST` classifies the operand as zero, already normalized, or needing shifts. `ST_SHIFT` performs one shift per cycle. `ST_ALIGN` pads to the budget with a down-counter. `ST_FINISH` raises `done` and commits the results.

The transitions are:
- IDLE→FETCH on start.
- FETCH→TEST always.
- TEST→SHIFT when the operand is non-zero with its top bit clear.
- TEST→ALIGN when the operand is zero (1 pad cycle) or when its top bit is set (3 pad cycles).
- SHIFT→SHIFT while the bit below the top is clear.
- SHIFT→ALIGN once the next shift sets the top bit (3 pad cycles).
- ALIGN→ALIGN while the pad count is above 1.
- ALIGN→FINISH when the pad count reaches 1.
- FINISH→IDLE always.

Top module: `nrm_unit`

## Requirements
- R1: After reset, `busy`, `done`, `acc_out`, `shift_cnt` and `zero_flag` are all 0.
- R2: A `start` high at a rising edge while idle captures `acc_in`, and `busy` is high in the cycle after that edge.
- R3: For a non-zero operand, `acc_out` equals the operand shifted left until bit 31 is 1, with zeros shifted in at bit 0.
- R4: `shift_cnt` equals the number of leading zero bits of a non-zero operand (0 to 31), zero-extended to 8 bits.
- R5: For a non-zero operand, `busy` stays high for exactly 6 + `shift_cnt` consecutive cycles, so at most 37 cycles.
- R6: For an all-zero operand, `acc_out` stays 0, `shift_cnt` is 0, `zero_flag` is 1, and `busy` stays high for exactly 4 cycles.
- R7: `zero_flag` is 0 after any non-zero operand.
- R8: `done` is high for exactly one cycle per operation, in the last cycle `busy` is high. The results are visible in the following cycle.
- R9: A `start` pulse while `busy` is high is ignored. The operation in flight keeps its operand, result and latency.
- R10: An operand whose bit 31 is already 1 is returned unchanged, with `shift_cnt` 0 and a 6-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (honoured only while idle) |
| acc_in | input | 32 | Accumulator operand, sampled with start |
| busy | output | 1 | High for every cycle of an operation |
| done | output | 1 | One-cycle pulse in the final busy cycle |
| acc_out | output | 32 | Normalized accumulator result |
| shift_cnt | output | 8 | Number of shift positions taken |
| zero_flag | output | 1 | Set when the operand was all zeroes |

## Verification
The assertions check the following on every cycle:
- `done` is followed by idle and never lasts two cycles.
- No shift is applied to a value whose top bit is already set.
- The shift count steps by one per shift cycle.
- A committed result is either left-justified or zero, with the zero flag agreeing.
- The busy time counted at `done` matches 4, or 6 plus the shift count.

Only the bench scenarios can show that the values themselves are right. They compare the result and count against arithmetic leading-zero counting over every one-hot operand, every low-bit mask and pseudo-random operands of every width. They also show that a start pulse injected mid-operation leaves the operation in flight unaffected.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TEST,
        ST_SHIFT,
        ST_ALIGN,
        ST_FINISH
    } nrm_state_t;
endpackage

// File: rtl/nrm_shifter.sv
module nrm_shifter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] op_in,
    output logic [DATA_W-1:0] work,
    output logic [CNT_W-1:0]  cnt,
    output logic              is_zero,
    output logic              top_bit,
    output logic              next_top
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work    <= '0;
            cnt     <= '0;
            is_zero <= 1'b0;
        end else if (load) begin
            work    <= op_in;
            cnt     <= '0;
            is_zero <= (op_in == '0);
        end else if (shift_en) begin
            work <= {work[DATA_W-2:0], 1'b0};
            cnt  <= cnt + CNT_W'(1);
        end
    end

    assign top_bit  = work[DATA_W-1];
    assign next_top = work[DATA_W-2];

    // R3
    no_shift_normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> !work[DATA_W-1]);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
    import nrm_pkg::*;
#(
    parameter int LAT_ZERO    = 4,
    parameter int LAT_NZ_BASE = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_zero,
    input  logic top_bit,
    input  logic next_top,
    output logic load,
    output logic shift_en,
    output logic wr_en,
    output logic busy,
    output logic done
);
    localparam int Z_TAIL  = LAT_ZERO - 3;
    localparam int NZ_TAIL = LAT_NZ_BASE - 3;
    localparam int MAX_TAIL = (Z_TAIL > NZ_TAIL) ? Z_TAIL : NZ_TAIL;
    localparam int PAD_W   = $clog2(MAX_TAIL + 1);

    nrm_state_t state, state_nx;
    logic [PAD_W-1:0] pad_q, pad_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pad_q <= '0;
        end else begin
            state <= state_nx;
            pad_q <= pad_nx;
        end
    end

    always_comb begin
        state_nx = state;
        pad_nx   = pad_q;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_TEST;
            ST_TEST: begin
                if (is_zero) begin
                    state_nx = ST_ALIGN;
                    pad_nx   = PAD_W'(Z_TAIL);
                end else if (top_bit) begin
                    state_nx = ST_ALIGN;
                    pad_nx   = PAD_W'(NZ_TAIL);
                end else begin
                    state_nx = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (next_top) begin
                    state_nx = ST_ALIGN;
                    pad_nx   = PAD_W'(NZ_TAIL);
                end
            end
            ST_ALIGN: begin
                if (pad_q <= PAD_W'(1)) state_nx = ST_FINISH;
                else pad_nx = pad_q - PAD_W'(1);
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = (state == ST_IDLE) && start;
        shift_en = (state == ST_SHIFT);
        wr_en    = (state == ST_FINISH);
        done     = (state == ST_FINISH);
        busy     = (state != ST_IDLE);
    end

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: rtl/nrm_result.sv
module nrm_result #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] work,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_zero,
    output logic [DATA_W-1:0] acc_out,
    output logic [CNT_W-1:0]  shift_cnt,
    output logic              zero_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_out   <= '0;
            shift_cnt <= '0;
            zero_flag <= 1'b0;
        end else if (wr_en) begin
            acc_out   <= work;
            shift_cnt <= cnt;
            zero_flag <= is_zero;
        end
    end

    // R3
    left_justified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (acc_out[DATA_W-1] || zero_flag));

    // R6 R7
    zero_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (zero_flag == (acc_out == '0)));
endmodule

// File: rtl/nrm_unit.sv
module nrm_unit #(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 8,
    parameter int LAT_ZERO    = 4,
    parameter int LAT_NZ_BASE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc_out,
    output logic [CNT_W-1:0]  shift_cnt,
    output logic              zero_flag
);
    localparam int LAT_W = $clog2(LAT_NZ_BASE + DATA_W + 1) + 1;

    logic              load, shift_en, wr_en;
    logic [DATA_W-1:0] work;
    logic [CNT_W-1:0]  cnt;
    logic              is_zero, top_bit, next_top;

    nrm_ctrl #(.LAT_ZERO(LAT_ZERO), .LAT_NZ_BASE(LAT_NZ_BASE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .is_zero(is_zero), .top_bit(top_bit), .next_top(next_top),
        .load(load), .shift_en(shift_en), .wr_en(wr_en),
        .busy(busy), .done(done)
    );

    nrm_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .op_in(acc_in), .work(work), .cnt(cnt),
        .is_zero(is_zero), .top_bit(top_bit), .next_top(next_top)
    );

    nrm_result #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .work(work), .cnt(cnt), .is_zero(is_zero),
        .acc_out(acc_out), .shift_cnt(shift_cnt), .zero_flag(zero_flag)
    );

    // Busy-cycle counter used only by the latency assertion
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_q <= '0;
        else if (load)   lat_q <= LAT_W'(1);
        else if (busy)   lat_q <= lat_q + LAT_W'(1);
    end

    // R5 R6
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lat_q == (is_zero ? LAT_W'(LAT_ZERO)
                                   : LAT_W'(LAT_NZ_BASE) + LAT_W'(cnt)));
endmodule

// File: tb/test_nrm_unit.sv
module test_nrm_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] acc_in = '0;
    logic        busy, done, zero_flag;
    logic [31:0] acc_out;
    logic [7:0]  shift_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    nrm_unit i_nrm_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
        .busy(busy), .done(done), .acc_out(acc_out),
        .shift_cnt(shift_cnt), .zero_flag(zero_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run did not end, act=%0d exp<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int lead_zeros(input logic [31:0] v);
        int k = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return k;
            k++;
        end
        return k;
    endfunction

    task automatic run_op(input logic [31:0] v, input bit poke);
        int n = 0, done_cnt = 0, done_at = 0, k, exp_lat;
        logic [31:0] exp_res;
        @(negedge clk);
        acc_in = v;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        acc_in = ~v;
        chk(busy == 1'b1, "R2 busy after start", {31'b0, busy}, 32'd1);
        while (busy && n < 100) begin
            n++;
            if (done) begin done_cnt++; done_at = n; end
            if (poke && n == 3) begin
                start  = 1'b1;
                acc_in = v ^ 32'h0F0F_3C3C;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (v == 32'd0) begin
            k = 0; exp_res = 32'd0; exp_lat = 4;
            chk(acc_out == 32'd0, "R6 zero result", acc_out, 32'd0);
            chk(shift_cnt == 8'd0, "R6 zero count", {24'b0, shift_cnt}, 32'd0);
            chk(zero_flag == 1'b1, "R6 zero flag", {31'b0, zero_flag}, 32'd1);
            chk(n == exp_lat, "R6 zero latency", n, exp_lat);
        end else begin
            k = lead_zeros(v);
            exp_res = v << k;
            exp_lat = 6 + k;
            chk(acc_out == exp_res, poke ? "R9 R3 result" : "R3 result", acc_out, exp_res);
            chk(shift_cnt == 8'(k), "R4 count", {24'b0, shift_cnt}, k);
            chk(zero_flag == 1'b0, "R7 flag clear", {31'b0, zero_flag}, 32'd0);
            chk(n == exp_lat, poke ? "R9 R5 latency" : "R5 latency", n, exp_lat);
            if (v[31]) begin
                chk(acc_out == v && n == 6 && shift_cnt == 8'd0,
                    "R10 already normalized", acc_out, v);
            end
        end
        chk(done_cnt == 1, "R8 done pulses", done_cnt, 1);
        chk(done_at == n, "R8 done in last busy cycle", done_at, n);
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", {30'b0, busy, done}, 32'd0);
        chk(acc_out == 32'd0, "R1 reset acc", acc_out, 32'd0);
        chk(shift_cnt == 8'd0 && zero_flag == 1'b0, "R1 reset count/flag",
            {23'b0, zero_flag, shift_cnt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(32'd0, 1'b0);
        run_op(32'hFFFF_FFFF, 1'b0);
        run_op(32'd0, 1'b1);
        for (int i = 0; i < 32; i++) run_op(32'd1 << i, 1'b0);
        for (int i = 0; i < 32; i++) run_op((32'd1 << i) | ((32'd1 << i) - 32'd1), 1'b0);
        for (int i = 0; i < 32; i++) run_op(32'd1 << i, 1'b1);
        for (int j = 0; j < 200; j++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            run_op(lfsr >> (j % 32), (j % 7) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule